// File: doc/BRIEF.md
# Register-Reservation Instruction Decoder

This block is the decode stage of an in-order five-stage pipeline. Fetch hands it a 32-bit instruction word and its program counter under a valid/ready handshake. The block holds one instruction at a time and classifies it by format (register, immediate or jump). It reads the operand registers from a small register file and sign-extends the immediate or jump offset. The resulting packet goes to execute. The packet carries the 7-bit operation code, three operand slots, the program counter, the destination the instruction has reserved (or -1 when it reserves none), and an illegal flag.

A reservation mask, one bit per register, tracks every register whose new value is still on its way to writeback. An instruction whose sources or destination are reserved waits in decode, and the block re-evaluates it every cycle. Writeback returns a value through one port. That port writes the register file, clears the register's reservation and forwards its data to decode in the same cycle. A flush empties the decode register. With the default parameters there are 16 general registers (indices 0 to 15) and 8 vector registers (indices 16 to 23), all in one 24-bit mask.

Top module: `reg_rsv_decode`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `rsv_mask` is all zero.
- R2: Bits [1:0] give the format: 00 register, 01 immediate, 10 jump, 11 illegal. `out_op` carries bits [6:0]. A format-11 word goes out with `out_illegal` set and `out_dst` equal to -1.
- R3: Register fields are A = [11:7], B = [16:12] and C = [21:17]. Index 0 always reads 0. Indices 16 to 23 address the vector registers. A referenced index of 24 or more marks the packet illegal, reads 0, causes no stall and reserves nothing.
- R4: The immediate-format constant is bits [31:17], sign-extended to 32 bits, in `out_s3`. The jump offset is bits [31:12], sign-extended, in `out_s2`.
- R5: A register-format instruction gives s1 = reg[A], s2 = reg[B] and s3 = reg[C], and reserves C. The compare opcodes 1000000 and 1000100 reserve nothing.
- R6: For an immediate-format instruction, s1 = reg[A], s2 = reg[B] and the destination is B. The loads 0000101 and 0001001 swap these roles: s1 = reg[B], s2 = reg[A], and the destination is A.
- R7: The stores 0101001 and 0101101 read both A and B as sources, stall on either one, and reserve nothing.
- R8: A jump-format instruction gives s1 = reg[A] and s3 = 0, and reserves nothing.
- R9: While any source of the held instruction is reserved, `out_valid` and `in_ready` are 0. The instruction is re-evaluated every cycle.
- R10: An instruction whose destination is already reserved also stalls.
- R11: On handoff (`out_valid` and `out_ready` both high) the destination bit is set in `rsv_mask` from the next cycle on, and `out_dst` names it. Register 0 is never reserved.
- R12: A writeback (`wb_valid`) writes the register, clears its bit and forwards `wb_data` to decode in the same cycle. A release and a new reservation of the same register in one cycle leave the bit set.
- R13: While `out_ready` is low, the offered packet stays valid and unchanged, and nothing is reserved.
- R14: `flush` empties decode. No handoff and no reservation happen in that cycle, and reservations already in `rsv_mask` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Discard the instruction held in decode |
| in_valid | input | 1 | Fetch offers a word |
| in_ready | output | 1 | Decode accepts the word this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Program counter of the word |
| out_valid | output | 1 | Decoded packet offered to execute |
| out_ready | input | 1 | Execute accepts the packet |
| out_op | output | 7 | Opcode and format bits |
| out_pc | output | 32 | Program counter of the packet |
| out_s1 | output | 32 | Operand slot 1 |
| out_s2 | output | 32 | Operand slot 2 |
| out_s3 | output | 32 | Operand slot 3 |
| out_dst | output | 6 | Reserved destination, signed, -1 for none |
| out_illegal | output | 1 | Illegal format or register index |
| wb_valid | input | 1 | Writeback returns a value |
| wb_idx | input | 5 | Register written and released |
| wb_data | input | 32 | Value written |
| rsv_mask | output | 24 | Registers currently reserved |

## Verification
The hardest case to reach is the same cycle in which writeback releases a register and decode hands off a new writer of that same register. It needs a reserved destination, a second writer stalled on it, and the release arriving while execute is ready. The bench builds this case with an explicit reserve, stall and release sequence. It then checks that the stalled instruction leaves on the release cycle with the forwarded value and that the bit stays set. A sweep over every register places a reservation and then reads the register through a rotating choice of source role. For each case the bench checks that decode holds until the release and then forwards the returned value.

// File: rtl/reg_rsv_decode.sv
module reg_rsv_decode #(
  parameter int NGPR = 16,
  parameter int NVEC = 8,
  parameter int FW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_instr,
  input  logic [31:0]          in_pc,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [6:0]           out_op,
  output logic [31:0]          out_pc,
  output logic [31:0]          out_s1,
  output logic [31:0]          out_s2,
  output logic [31:0]          out_s3,
  output logic signed [FW:0]   out_dst,
  output logic                 out_illegal,
  input  logic                 wb_valid,
  input  logic [FW-1:0]        wb_idx,
  input  logic [31:0]          wb_data,
  output logic [NGPR+NVEC-1:0] rsv_mask
);
  localparam int NREG  = NGPR + NVEC;
  localparam int NSLOT = 1 << FW;
  localparam int A_LSB = 7;
  localparam int B_LSB = A_LSB + FW;
  localparam int C_LSB = B_LSB + FW;
  localparam int IW    = 32 - C_LSB;
  localparam int JW    = 32 - B_LSB;

  localparam logic [6:0] OP_CMP    = 7'b1000000;
  localparam logic [6:0] OP_CEV    = 7'b1000100;
  localparam logic [6:0] OP_LOAD   = 7'b0000101;
  localparam logic [6:0] OP_LOADV  = 7'b0001001;
  localparam logic [6:0] OP_STORE  = 7'b0101001;
  localparam logic [6:0] OP_STOREV = 7'b0101101;

  logic            dv;
  logic [31:0]     ir, pc_q;
  logic [NREG-1:0] rsv_q, rel_vec, set_vec;
  logic [NSLOT-1:0] busy;
  logic [31:0]     rf [NSLOT];

  logic [FW-1:0] fa, fb, fc, src1, src2, dst;
  logic is_r, is_i, is_j, is_bad, is_ld, is_st, is_cmp;
  logic use1, use2, wr, oob_a, oob_b, oob_c, illegal, rsv, stall, fire;
  logic [31:0] imm_i, off_j;

  assign fa     = ir[A_LSB +: FW];
  assign fb     = ir[B_LSB +: FW];
  assign fc     = ir[C_LSB +: FW];
  assign is_r   = ir[1:0] == 2'b00;
  assign is_i   = ir[1:0] == 2'b01;
  assign is_j   = ir[1:0] == 2'b10;
  assign is_bad = ir[1:0] == 2'b11;
  assign is_ld  = is_i && (ir[6:0] == OP_LOAD || ir[6:0] == OP_LOADV);
  assign is_st  = is_i && (ir[6:0] == OP_STORE || ir[6:0] == OP_STOREV);
  assign is_cmp = is_r && (ir[6:0] == OP_CMP || ir[6:0] == OP_CEV);
  assign imm_i  = {{(32-IW){ir[31]}}, ir[31:C_LSB]};
  assign off_j  = {{(32-JW){ir[31]}}, ir[31:B_LSB]};

  assign oob_a   = 32'(fa) >= NREG;
  assign oob_b   = 32'(fb) >= NREG;
  assign oob_c   = 32'(fc) >= NREG;
  assign illegal = is_bad || oob_a || (oob_b && !is_j) || (oob_c && is_r);

  function automatic logic [31:0] rd(input logic [FW-1:0] i);
    if (i == '0 || 32'(i) >= NREG) return '0;
    if (wb_valid && wb_idx == i) return wb_data;
    return rf[i];
  endfunction

  always_comb begin
    src1 = fa; src2 = fb; dst = fb;
    use1 = 1'b0; use2 = 1'b0; wr = 1'b0;
    if (is_r) begin
      use1 = 1'b1; use2 = 1'b1; dst = fc; wr = !is_cmp;
    end else if (is_i) begin
      use1 = 1'b1;
      if (is_st) use2 = 1'b1;
      else if (is_ld) begin src1 = fb; dst = fa; wr = 1'b1; end
      else wr = 1'b1;
    end else if (is_j) begin
      use1 = 1'b1;
    end
  end

  always_comb begin
    rel_vec = '0;
    if (wb_valid && 32'(wb_idx) < NREG) rel_vec[wb_idx] = 1'b1;
    busy = '0;
    busy[NREG-1:0] = rsv_q & ~rel_vec;
  end

  assign rsv   = wr && dst != '0 && !illegal;
  assign stall = !illegal && ((use1 && busy[src1]) || (use2 && busy[src2]) || (rsv && busy[dst]));

  assign out_valid   = dv && !stall && !flush;
  assign fire        = out_valid && out_ready;
  assign in_ready    = !flush && (!dv || fire);
  assign out_op      = ir[6:0];
  assign out_pc      = pc_q;
  assign out_illegal = illegal;
  assign out_dst     = rsv ? $signed({1'b0, dst}) : '1;
  assign out_s1      = is_bad ? '0 : rd(src1);
  assign out_s2      = is_bad ? '0 : (is_j ? off_j : rd(is_ld ? fa : fb));
  assign out_s3      = is_r ? rd(fc) : (is_i ? imm_i : '0);
  assign rsv_mask    = rsv_q;

  always_comb begin
    set_vec = '0;
    if (fire && rsv) set_vec[dst] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv <= 1'b0; ir <= '0; pc_q <= '0; rsv_q <= '0;
      for (int i = 0; i < NSLOT; i++) rf[i] <= '0;
    end else begin
      rsv_q <= (rsv_q & ~rel_vec) | set_vec;
      if (wb_valid && wb_idx != '0 && 32'(wb_idx) < NREG) rf[wb_idx] <= wb_data;
      if (flush) dv <= 1'b0;
      else if (in_valid && in_ready) begin
        dv <= 1'b1; ir <= in_instr; pc_q <= in_pc;
      end else if (fire) dv <= 1'b0;
    end
  end

  assert_reg0_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv_q[0]);
  assert_handoff_sets_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((rsv_q & $past(set_vec)) == $past(set_vec)));
  assert_release_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> ((rsv_q & $past(rel_vec & ~set_vec)) == '0));
  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_pc) && $stable(out_op) && $stable(out_dst)));
  assert_flush_empties_R14: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: tb/reg_rsv_decode_bench.sv
module reg_rsv_decode_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 24;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;
  localparam logic [6:0] ADD = 7'b0000100, ADDI = 7'b0001101, LOAD = 7'b0000101,
    LOADV = 7'b0001001, STORE = 7'b0101001, STOREV = 7'b0101101, CMP = 7'b1000000,
    CEV = 7'b1000100, JRL = 7'b0001010, BGT = 7'b0010110;

  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, out_ready = 1, wb_valid = 0;
  logic in_ready, out_valid, out_illegal;
  logic [31:0] in_instr = 0, in_pc = 0, wb_data = 0, out_pc, out_s1, out_s2, out_s3;
  logic [4:0] wb_idx = 0;
  logic [6:0] out_op;
  logic signed [5:0] out_dst;
  logic [NREG-1:0] rsv_mask, exp_mask;
  logic [31:0] rfm [32];
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_rsv_decode u_reg_rsv_decode (.clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_pc(out_pc),
    .out_s1(out_s1), .out_s2(out_s2), .out_s3(out_s3), .out_dst(out_dst),
    .out_illegal(out_illegal), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .rsv_mask(rsv_mask));

  function automatic logic [31:0] enc_r(input logic [6:0] op, input logic [4:0] a, b, c);
    return {10'b0, c, b, a, op};
  endfunction
  function automatic logic [31:0] enc_i(input logic [6:0] op, input logic [4:0] a, b, input logic [14:0] imm);
    return {imm, b, a, op};
  endfunction
  function automatic logic [31:0] enc_j(input logic [6:0] op, input logic [4:0] a, input logic [19:0] off);
    return {off, a, op};
  endfunction
  function automatic logic [31:0] ev(input int i);
    return (i == 0 || i >= NREG) ? 32'h0 : rfm[i];
  endfunction
  function automatic logic [31:0] dstv();
    return {{26{out_dst[5]}}, out_dst};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_pkt(input string tag, input logic [31:0] s1, s2, s3, dst, input logic ill);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " s1"}, out_s1, s1);
    check({tag, " s2"}, out_s2, s2);
    check({tag, " s3"}, out_s3, s3);
    check({tag, " dst"}, dstv(), dst);
    check({tag, " illegal"}, {31'b0, out_illegal}, {31'b0, ill});
  endtask

  task automatic push(input logic [31:0] w, input logic [31:0] pc);
    in_valid = 1; in_instr = w; in_pc = pc;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic release_reg(input int idx, input logic [31:0] d);
    wb_valid = 1; wb_idx = idx[4:0]; wb_data = d;
    @(negedge clk);
    wb_valid = 0;
    if (idx != 0 && idx < NREG) begin rfm[idx] = d; exp_mask[idx] = 1'b0; end
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] nv, sv;
    for (int i = 0; i < 32; i++) rfm[i] = 0;
    exp_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 out_valid", {31'b0, out_valid}, 0);
    check("R1 in_ready", {31'b0, in_ready}, 1);
    check("R1 mask", {8'b0, rsv_mask}, 0);

    for (int i = 0; i < 32; i++) release_reg(i, 32'h1000_0000 + i * 32'h0101_0101);
    check("R12 writes leave mask empty", {8'b0, rsv_mask}, 0);

    // R3 read sweep incl. register zero and the vector range
    for (int a = 0; a < NREG; a++) begin
      int b = (a + 7) % NREG;
      int c = (a + 13) % NREG;
      push(enc_r(CMP, a[4:0], b[4:0], c[4:0]), 32'h400 + a);
      expect_pkt("R3 R5 read", ev(a), ev(b), ev(c), NONE, 0);
      check("R2 op", {25'b0, out_op}, {25'b0, CMP});
      check("R3 pc", out_pc, 32'h400 + a);
      step();
    end

    push(enc_r(ADD, 25, 1, 2), 0);
    expect_pkt("R3 bad source", 0, ev(1), ev(2), NONE, 1);
    step();
    push(enc_i(ADDI, 1, 30, 15'h3), 0);
    expect_pkt("R3 bad dest", ev(1), 0, 3, NONE, 1);
    step();
    push(32'h0000_0F0F, 0);
    expect_pkt("R2 format 11", 0, 0, 0, NONE, 1);
    step();
    check("R3 R2 illegal reserves nothing", {8'b0, rsv_mask}, 0);

    // R4 immediate and offset sign extension
    for (int k = 0; k < 16; k++) begin
      logic [14:0] im = 15'(k * 32'h0891) ^ (k[0] ? 15'h4000 : 15'h0);
      logic [19:0] of = 20'(k * 32'h12345) ^ (k[1] ? 20'h80000 : 20'h0);
      push(enc_i(ADDI, 3, 0, im), 0);
      expect_pkt("R4 R6 imm", ev(3), 0, {{17{im[14]}}, im}, NONE, 0);
      step();
      push(enc_j(BGT, 2, of), 0);
      expect_pkt("R4 R8 jump", ev(2), {{12{of[19]}}, of}, 0, NONE, 0);
      step();
    end

    // reserve / stall / release sweep over every register
    for (int d = 1; d < NREG; d++) begin
      int v = d % 6;
      logic [31:0] w;
      push(enc_i(ADDI, 0, d[4:0], 15'h0), 0);
      expect_pkt("R6 R11 writer", 0, ev(d), 0, d, 0);
      step();
      exp_mask[d] = 1'b1;
      check("R11 bit set", {8'b0, rsv_mask}, {8'b0, exp_mask});
      case (v)
        0: w = enc_r(ADD, d[4:0], 0, 0);
        1: w = enc_r(ADD, 0, d[4:0], 0);
        2: w = enc_i(ADDI, d[4:0], 0, 15'h5);
        3: w = enc_i(LOAD, 0, d[4:0], 15'h5);
        4: w = enc_i(STORE, 0, d[4:0], 15'h5);
        default: w = enc_j(JRL, d[4:0], 20'h3);
      endcase
      push(w, 0);
      check("R9 stalled", {31'b0, out_valid}, 0);
      check("R9 in_ready low", {31'b0, in_ready}, 0);
      step(); step();
      check("R9 still stalled", {31'b0, out_valid}, 0);
      nv = 32'hA000_0000 + d;
      wb_valid = 1; wb_idx = d[4:0]; wb_data = nv;
      #1;
      check("R12 R9 proceeds on release", {31'b0, out_valid}, 1);
      sv = (v == 1 || v == 4) ? out_s2 : out_s1;
      check("R12 forwarded value", sv, nv);
      @(negedge clk);
      wb_valid = 0; rfm[d] = nv; exp_mask[d] = 1'b0;
      #1;
      check("R12 bit cleared", {8'b0, rsv_mask}, {8'b0, exp_mask});
      check("R9 handed off", {31'b0, out_valid}, 0);
    end

    // R5 destination C, R10 WAW stall, R12 same-cycle release and reserve
    push(enc_r(ADD, 1, 2, 9), 0);
    expect_pkt("R5 dest C", ev(1), ev(2), ev(9), 9, 0);
    step(); exp_mask[9] = 1'b1;
    push(enc_r(ADD, 0, 0, 9), 0);
    check("R10 dest reserved stalls", {31'b0, out_valid}, 0);
    wb_valid = 1; wb_idx = 9; wb_data = 32'h5555_AAAA;
    #1;
    check("R10 proceeds on release", {31'b0, out_valid}, 1);
    check("R12 forwarded s3", out_s3, 32'h5555_AAAA);
    @(negedge clk);
    wb_valid = 0; rfm[9] = 32'h5555_AAAA;
    #1;
    check("R12 release then reserve keeps bit", {8'b0, rsv_mask}, {8'b0, exp_mask});
    release_reg(9, 32'h99);
    check("R12 final release", {8'b0, rsv_mask}, 0);

    push(enc_r(CEV, 1, 2, 9), 0);
    expect_pkt("R5 CEV no dest", ev(1), ev(2), ev(9), NONE, 0);
    step();

    // R6 load roles
    push(enc_i(LOAD, 7, 3, 15'h7FFF), 0);
    expect_pkt("R6 load", ev(3), ev(7), NONE, 7, 0);
    step(); exp_mask[7] = 1'b1;
    check("R6 load reserves A", {8'b0, rsv_mask}, {8'b0, exp_mask});
    release_reg(7, 32'h77);
    push(enc_i(LOADV, 20, 4, 15'h1), 0);
    expect_pkt("R6 vector load", ev(4), ev(20), 1, 20, 0);
    step(); exp_mask[20] = 1'b1;
    release_reg(20, 32'h2020);
    check("R6 vector released", {8'b0, rsv_mask}, 0);

    // R7 stores
    push(enc_i(STORE, 5, 6, 15'h10), 0);
    expect_pkt("R7 store", ev(5), ev(6), 32'h10, NONE, 0);
    step();
    push(enc_i(STOREV, 17, 18, 15'h4001), 0);
    expect_pkt("R7 vector store", ev(17), ev(18), 32'hFFFF_C001, NONE, 0);
    step();
    check("R7 store reserves nothing", {8'b0, rsv_mask}, 0);

    // R13 hold while not ready
    out_ready = 0;
    push(enc_i(ADDI, 0, 12, 15'h1), 32'h88);
    expect_pkt("R13 offered", 0, ev(12), 1, 12, 0);
    step(); step(); step();
    check("R13 still valid", {31'b0, out_valid}, 1);
    check("R13 pc held", out_pc, 32'h88);
    check("R13 in_ready low", {31'b0, in_ready}, 0);
    check("R13 nothing reserved", {8'b0, rsv_mask}, 0);
    out_ready = 1;
    step(); exp_mask[12] = 1'b1;
    check("R13 reserved after handoff", {8'b0, rsv_mask}, {8'b0, exp_mask});
    release_reg(12, 32'h12);

    // R14 flush of a stalled instruction and of an offered one
    push(enc_i(ADDI, 0, 6, 15'h0), 0);
    step(); exp_mask[6] = 1'b1;
    push(enc_r(ADD, 6, 0, 0), 0);
    check("R14 stalled before flush", {31'b0, out_valid}, 0);
    flush = 1;
    @(negedge clk);
    flush = 0;
    #1;
    check("R14 empty", {31'b0, out_valid}, 0);
    check("R14 ready again", {31'b0, in_ready}, 1);
    check("R14 mask kept", {8'b0, rsv_mask}, {8'b0, exp_mask});
    release_reg(6, 32'h66);
    push(enc_i(ADDI, 0, 11, 15'h0), 0);
    check("R14 offered", {31'b0, out_valid}, 1);
    flush = 1;
    #1;
    check("R14 no handoff during flush", {31'b0, out_valid}, 0);
    @(negedge clk);
    flush = 0;
    #1;
    check("R14 no reservation", {8'b0, rsv_mask}, 0);
    check("R14 decode empty", {31'b0, out_valid}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule